// File: doc/BRIEF.md
# Vector branch condition reduction unit

This unit turns a vector of predicated per-element condition tests into one branch decision. After a start pulse it walks the elements of the vector one per clock, in ascending index order. For each element it reads a 4-bit condition field from an internal file of 128 fields and picks one bit of that field. It compares that bit against the requested sense and folds the outcome into a running result. In "all" mode the result is the AND of every element test. In "any" mode it is their OR. The walk stops as soon as the outcome is settled, so elements past that point are never tested.

Predication controls each element. A masked-out element is either skipped outright or tested against a substitute bit. An optional length-truncation mode stops the walk at the first element whose test equals a chosen polarity, and reports a new vector length that either includes or excludes that element. A scalar flag limits the walk to one tested element. The unit exports how many elements were actually tested, so a loop-counter unit downstream can subtract that count. The condition file has a simple write port that is used to load it.

Top module: `vbr_reduce`

## Requirements
- R1: Element i reads condition field (base_field + i) mod 128, or base_field itself when m_scalar is set. bit_sel = k tests bit k of that field, where bit k is wr_data[k] as the field was written.
- R2: An element test passes when bo_force is 1, or when the tested bit equals bo_sense.
- R3: With m_all = 1 the result starts at 1, is ANDed with each test, and the walk stops at the first failing test. With m_all = 0 the result starts at 0, is ORed with each test, and the walk stops at the first passing test. Later elements are not tested.
- R4: An element whose pmask bit is 0 while m_sz = 0 is skipped. It does not affect the result and is not counted.
- R5: An element whose pmask bit is 0 while m_sz = 1 is tested with m_snz in place of the condition bit, and it is counted.
- R6: With m_vlset = 1, the walk stops on the first tested element i whose test outcome equals m_vsb. vl_new_valid then goes high with vl_new = i+1 when m_vli = 1, or vl_new = i when m_vli = 0. Otherwise vl_new_valid stays 0.
- R7: With m_scalar = 1, the walk ends after the first element that is not skipped.
- R8: tested_cnt equals the number of elements that were not skipped, up to and including the stop element.
- R9: With vl = 0, done is high in the cycle right after start is sampled. cond_ok then equals m_all, and vl_new_valid is 0.
- R10: start is ignored while busy is high, and done is a one-cycle pulse.
- R11: After reset, busy, done, cond_ok, vl_new_valid, vl_new and tested_cnt are all 0.
- R12: A write with wr_en = 1 stores wr_data into field wr_idx, and later walks read that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk. Sampled only while idle |
| vl | input | 7 | Vector length, 0..64. Larger values are clamped to 64 |
| pmask | input | 64 | Predicate bit per element |
| base_field | input | 7 | First condition field index |
| bit_sel | input | 2 | Bit of the field to test |
| bo_force | input | 1 | Force every element test to pass |
| bo_sense | input | 1 | Bit value that counts as a pass |
| m_all | input | 1 | 1: AND reduction, 0: OR reduction |
| m_sz | input | 1 | Test masked elements with m_snz instead of skipping them |
| m_snz | input | 1 | Substitute bit for masked elements |
| m_vlset | input | 1 | Enable length truncation |
| m_vli | input | 1 | Truncated length includes the deciding element |
| m_vsb | input | 1 | Test outcome that triggers truncation |
| m_scalar | input | 1 | Test a single element only |
| wr_en | input | 1 | Condition file write enable |
| wr_idx | input | 7 | Condition file write index |
| wr_data | input | 4 | Condition field value to write |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| cond_ok | output | 1 | Final branch condition |
| vl_new | output | 7 | Truncated vector length |
| vl_new_valid | output | 1 | vl_new carries a truncation |
| tested_cnt | output | 7 | Number of elements tested |

## Verification
The hardest situation to reach is a walk whose stop point depends on several rules at once. Examples are a masked element that is skipped right before the deciding one, a substituted bit that ends an AND walk early, and a truncation hit that precedes the ordinary early exit. The field contents also wrap past index 127. To reach these, the bench loads every field with a computed pattern and runs hand-picked mask and mode combinations that place the decisive element at a known index. It then adds a long series of random masks, lengths and mode mixes. A second start pulse is placed in the middle of a long walk, so the bench can show that start is ignored while busy.

// File: rtl/vbr_pkg.sv
package vbr_pkg;

    localparam int FIELD_BITS = 4;
    localparam int SEL_BITS   = $clog2(FIELD_BITS);

    // mode bits captured at start
    typedef struct packed {
        logic all_m;
        logic sz;
        logic snz;
        logic vlset;
        logic vli;
        logic vsb;
        logic scalar;
        logic bo_force;
        logic bo_sense;
    } vbr_mode_t;

    // per-element outcome
    typedef struct packed {
        logic skip;
        logic pass;
    } vbr_elem_t;

    function automatic logic elem_pass(logic tbit, logic force_pass, logic sense);
        return force_pass | (tbit == sense);
    endfunction

endpackage

// File: rtl/vbr_crfile.sv
module vbr_crfile #(
    parameter int NFIELD = 128,
    parameter int FW     = $clog2(NFIELD)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic [FW-1:0]                   wr_idx,
    input  logic [vbr_pkg::FIELD_BITS-1:0]  wr_data,
    input  logic [FW-1:0]                   rd_idx,
    output logic [vbr_pkg::FIELD_BITS-1:0]  rd_data
);
    logic [vbr_pkg::FIELD_BITS-1:0] mem [NFIELD];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NFIELD; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> mem[$past(wr_idx)] == $past(wr_data)) // R12
        else $error("write not stored");
endmodule

// File: rtl/vbr_elem_test.sv
module vbr_elem_test
    import vbr_pkg::*;
(
    input  logic [FIELD_BITS-1:0] field,
    input  logic [SEL_BITS-1:0]   bit_sel,
    input  logic                  pred,
    input  vbr_mode_t             mode,
    output vbr_elem_t             res
);
    logic tbit;

    always_comb begin
        tbit     = pred ? field[bit_sel] : mode.snz;
        res.skip = ~pred & ~mode.sz;
        res.pass = elem_pass(tbit, mode.bo_force, mode.bo_sense);
    end

    always_comb begin
        if (!pred && mode.sz && !mode.bo_force)
            AST_SUBST_BIT: assert (res.pass == (mode.snz == mode.bo_sense)) // R5
                else $error("substitute bit not used");
    end
endmodule

// File: rtl/vbr_reduce.sv
module vbr_reduce
    import vbr_pkg::*;
#(
    parameter int MAXVL  = 64,
    parameter int NFIELD = 128,
    parameter int VLW    = $clog2(MAXVL + 1),
    parameter int FW     = $clog2(NFIELD)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [VLW-1:0]        vl,
    input  logic [MAXVL-1:0]      pmask,
    input  logic [FW-1:0]         base_field,
    input  logic [1:0]            bit_sel,
    input  logic                  bo_force,
    input  logic                  bo_sense,
    input  logic                  m_all,
    input  logic                  m_sz,
    input  logic                  m_snz,
    input  logic                  m_vlset,
    input  logic                  m_vli,
    input  logic                  m_vsb,
    input  logic                  m_scalar,
    input  logic                  wr_en,
    input  logic [FW-1:0]         wr_idx,
    input  logic [FIELD_BITS-1:0] wr_data,
    output logic                  busy,
    output logic                  done,
    output logic                  cond_ok,
    output logic [VLW-1:0]        vl_new,
    output logic                  vl_new_valid,
    output logic [VLW-1:0]        tested_cnt
);
    localparam int SW = $clog2(MAXVL);

    vbr_mode_t             mode_in, mode_q;
    logic                  busy_q, done_q, cond_q, vl_valid_q, acc_q;
    logic [VLW-1:0]        vl_q, cnt_q, vl_new_q, vl_clamped;
    logic [SW-1:0]         step_q;
    logic [MAXVL-1:0]      pmask_q;
    logic [FW-1:0]         base_q, field_idx;
    logic [SEL_BITS-1:0]   bsel_q;
    logic [FIELD_BITS-1:0] field;
    vbr_elem_t             er;
    logic                  acc_nx, hit, stop_early, last, finish;

    always_comb begin
        mode_in = '{all_m: m_all, sz: m_sz, snz: m_snz, vlset: m_vlset,
                    vli: m_vli, vsb: m_vsb, scalar: m_scalar,
                    bo_force: bo_force, bo_sense: bo_sense};
        vl_clamped = (vl > VLW'(MAXVL)) ? VLW'(MAXVL) : vl;
    end

    // field index: advances with the step unless scalar
    assign field_idx = mode_q.scalar ? base_q : base_q + FW'(step_q);

    vbr_crfile #(.NFIELD(NFIELD), .FW(FW)) u_crf (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(field_idx), .rd_data(field)
    );

    vbr_elem_test u_et (
        .field(field), .bit_sel(bsel_q), .pred(pmask_q[step_q]),
        .mode(mode_q), .res(er)
    );

    always_comb begin
        if (er.skip)          acc_nx = acc_q;
        else if (mode_q.all_m) acc_nx = acc_q & er.pass;
        else                  acc_nx = acc_q | er.pass;
        hit        = ~er.skip & mode_q.vlset & (er.pass == mode_q.vsb);
        stop_early = ~er.skip & ((mode_q.all_m ? ~er.pass : er.pass) | mode_q.scalar);
        last       = (VLW'(step_q) + VLW'(1)) == vl_q;
        finish     = hit | stop_early | last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0; done_q <= 1'b0; cond_q <= 1'b0; vl_valid_q <= 1'b0;
            vl_new_q <= '0; cnt_q <= '0; acc_q <= 1'b0; step_q <= '0;
            vl_q <= '0; pmask_q <= '0; base_q <= '0; bsel_q <= '0; mode_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    mode_q     <= mode_in;
                    vl_q       <= vl_clamped;
                    pmask_q    <= pmask;
                    base_q     <= base_field;
                    bsel_q     <= bit_sel;
                    step_q     <= '0;
                    cnt_q      <= '0;
                    vl_valid_q <= 1'b0;
                    vl_new_q   <= '0;
                    acc_q      <= m_all;
                    if (vl_clamped == '0) begin
                        done_q <= 1'b1;
                        cond_q <= m_all;
                    end else begin
                        busy_q <= 1'b1;
                    end
                end
            end else begin
                acc_q <= acc_nx;
                if (!er.skip) cnt_q <= cnt_q + VLW'(1);
                if (finish) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    cond_q <= acc_nx;
                    if (hit) begin
                        vl_valid_q <= 1'b1;
                        vl_new_q   <= mode_q.vli ? VLW'(step_q) + VLW'(1) : VLW'(step_q);
                    end
                end else begin
                    step_q <= step_q + SW'(1);
                end
            end
        end
    end

    assign busy         = busy_q;
    assign done         = done_q;
    assign cond_ok      = cond_q;
    assign vl_new       = vl_new_q;
    assign vl_new_valid = vl_valid_q;
    assign tested_cnt   = cnt_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) // R10
        else $error("done longer than one cycle");
    AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy && start |=> $stable(vl_q) && $stable(base_q) && $stable(pmask_q)) // R10
        else $error("start accepted while busy");
    AST_VL0_RESULT: assert property (@(posedge clk) disable iff (rst)
        done && vl_q == '0 |-> cond_ok == mode_q.all_m && !vl_new_valid) // R9
        else $error("empty vector result wrong");
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        done |-> tested_cnt <= vl_q) // R8
        else $error("tested count exceeds length");
    AST_SKIP_NOCOUNT: assert property (@(posedge clk) disable iff (rst)
        busy && er.skip |=> tested_cnt == $past(tested_cnt)) // R4
        else $error("skipped element counted");
    AST_SCALAR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done && mode_q.scalar |-> tested_cnt <= VLW'(1)) // R7
        else $error("scalar walk tested more than one");
    AST_VLNEW_BOUND: assert property (@(posedge clk) disable iff (rst)
        vl_new_valid |-> vl_new <= vl_q) // R6
        else $error("truncated length too large");
endmodule

// File: tb/sim_vbr_reduce.sv
module sim_vbr_reduce;
    import vbr_pkg::*;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [6:0] vl = '0, base_field = '0, wr_idx = '0;
    logic [63:0] pmask = '0;
    logic [1:0] bit_sel = '0;
    logic bo_force = 0, bo_sense = 0, m_all = 0, m_sz = 0, m_snz = 0;
    logic m_vlset = 0, m_vli = 0, m_vsb = 0, m_scalar = 0, wr_en = 0;
    logic [3:0] wr_data = '0;
    logic busy, done, cond_ok, vl_new_valid;
    logic [6:0] vl_new, tested_cnt;

    int nvec = 0, nbad = 0;
    logic [3:0] mirror [128];

    typedef struct {
        logic       c;
        logic       v;
        logic [6:0] nl;
        logic [6:0] cnt;
        string      tag;
    } exp_t;
    exp_t sbq [$];

    always #5 clk = ~clk;

    vbr_reduce u0 (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // reference model written from the requirements
    function automatic exp_t model(input logic [6:0] l, input logic [63:0] pm,
                                   input logic [6:0] b, input logic [1:0] bs,
                                   input vbr_mode_t md, input string tag);
        exp_t e;
        int n;
        n = (l > 64) ? 64 : int'(l);
        e.c = md.all_m; e.v = 0; e.nl = 0; e.cnt = 0; e.tag = tag;
        for (int i = 0; i < n; i++) begin
            logic tb, ok;
            logic [6:0] f;
            if (!pm[i] && !md.sz) continue;
            f  = md.scalar ? b : 7'(b + 7'(i));
            tb = pm[i] ? mirror[f][bs] : md.snz;
            ok = md.bo_force || (tb == md.bo_sense);
            e.c = md.all_m ? (e.c & ok) : (e.c | ok);
            e.cnt++;
            if (md.vlset && ok == md.vsb) begin
                e.v = 1; e.nl = md.vli ? 7'(i + 1) : 7'(i);
                break;
            end
            if (md.all_m ? !ok : ok) break;
            if (md.scalar) break;
        end
        return e;
    endfunction

    // monitor: pop and compare on each done pulse
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sbq.size() == 0) begin
                chk(0, "R10 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk(cond_ok == e.c, {e.tag, " cond_ok"}, cond_ok, e.c);
                chk(vl_new_valid == e.v, {e.tag, " R6 vl_new_valid"}, vl_new_valid, e.v);
                if (e.v) chk(vl_new == e.nl, {e.tag, " R6 vl_new"}, vl_new, e.nl);
                chk(tested_cnt == e.cnt, {e.tag, " R8 tested_cnt"}, tested_cnt, e.cnt);
            end
        end
    end

    task automatic run_case(input logic [6:0] l, input logic [63:0] pm, input logic [6:0] b,
                            input logic [1:0] bs, input vbr_mode_t md, input string tag,
                            input bit extra_start);
        sbq.push_back(model(l, pm, b, bs, md, tag));
        vl = l; pmask = pm; base_field = b; bit_sel = bs;
        {m_all, m_sz, m_snz, m_vlset, m_vli, m_vsb, m_scalar, bo_force, bo_sense} = md;
        start = 1;
        @(negedge clk);
        start = 0;
        if (l == 0) chk(done == 1, "R9 done timing", done, 1);
        if (extra_start) begin
            @(negedge clk);
            vl = 0; m_all = ~m_all; base_field = b + 7'd9; start = 1;
            @(negedge clk);
            start = 0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
        chk(done == 0, {tag, " R10 done pulse"}, done, 0);
        repeat (3) @(negedge clk);
        chk(sbq.size() == 0, {tag, " R10 one result"}, sbq.size(), 0);
    endtask

    function automatic vbr_mode_t mk(input bit a, sz, snz, vs, vli, vsb, sc, bf, bsn);
        vbr_mode_t m;
        m = '{all_m: a, sz: sz, snz: snz, vlset: vs, vli: vli, vsb: vsb,
              scalar: sc, bo_force: bf, bo_sense: bsn};
        return m;
    endfunction

    initial begin
        #(200000 * 10);
        chk(0, "watchdog expired", 0, 1);
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R11 reset state
        chk(busy == 0, "R11 busy", busy, 0);
        chk(done == 0, "R11 done", done, 0);
        chk(cond_ok == 0, "R11 cond_ok", cond_ok, 0);
        chk(vl_new_valid == 0 && vl_new == 0, "R11 vl_new", vl_new, 0);
        chk(tested_cnt == 0, "R11 tested_cnt", tested_cnt, 0);

        // R12 load condition file with a computed pattern
        for (int k = 0; k < 128; k++) begin
            mirror[k] = 4'((k * 5 + (k >> 3)) ^ 9);
            wr_en = 1; wr_idx = 7'(k); wr_data = mirror[k];
            @(negedge clk);
        end
        wr_en = 0;

        // R12/R1: single field reads, each bit position
        for (int k = 0; k < 4; k++)
            run_case(7'd1, 64'h1, 7'd37, 2'(k), mk(1,0,0,0,0,0,0,0,1), "R12 R1 bit read", 0);
        // R3 any: stop at first pass
        run_case(7'd20, '1, 7'd0, 2'd0, mk(0,0,0,0,0,0,0,0,1), "R3 any", 0);
        // R3 all: stop at first fail
        run_case(7'd20, '1, 7'd0, 2'd0, mk(1,0,0,0,0,0,0,0,1), "R3 all", 0);
        // R2 force: all pass over full length, R8 count = 30
        run_case(7'd30, '1, 7'd4, 2'd2, mk(1,0,0,0,0,0,0,1,0), "R2 force all", 0);
        // R2 force in any mode: one element tested
        run_case(7'd30, '1, 7'd4, 2'd2, mk(0,0,0,0,0,0,0,1,0), "R2 force any", 0);
        // R4 skipped elements, sparse mask
        run_case(7'd16, 64'h8421, 7'd10, 2'd1, mk(1,0,0,0,0,0,0,0,0), "R4 skip", 0);
        run_case(7'd16, 64'h0, 7'd10, 2'd1, mk(0,0,0,0,0,0,0,0,1), "R4 all masked", 0);
        // R5 substitution
        run_case(7'd12, 64'h0, 7'd3, 2'd0, mk(1,1,1,0,0,0,0,0,1), "R5 snz one", 0);
        run_case(7'd12, 64'h0F0, 7'd3, 2'd0, mk(1,1,0,0,0,0,0,0,1), "R5 snz zero", 0);
        // R6 truncation include/exclude, both polarities
        run_case(7'd24, '1, 7'd50, 2'd3, mk(1,0,0,1,1,0,0,0,1), "R6 vli", 0);
        run_case(7'd24, '1, 7'd50, 2'd3, mk(1,0,0,1,0,0,0,0,1), "R6 no vli", 0);
        run_case(7'd24, 64'hFFF0, 7'd50, 2'd3, mk(0,0,0,1,0,1,0,0,0), "R6 vsb", 0);
        // R7 scalar after skipped elements
        run_case(7'd10, 64'h20, 7'd77, 2'd1, mk(1,0,0,0,0,0,1,0,1), "R7 scalar", 0);
        run_case(7'd10, '1, 7'd77, 2'd1, mk(0,0,0,0,0,0,1,0,0), "R7 scalar any", 0);
        // R1 wrap past field 127, full length 64
        run_case(7'd64, '1, 7'd120, 2'd0, mk(1,0,0,0,0,0,0,1,0), "R1 wrap", 0);
        run_case(7'd64, '1, 7'd120, 2'd1, mk(0,0,0,0,0,0,0,0,0), "R1 wrap any", 0);
        // R9 empty vector
        run_case(7'd0, '1, 7'd0, 2'd0, mk(1,0,0,1,1,0,0,0,0), "R9 empty all", 0);
        run_case(7'd0, '1, 7'd0, 2'd0, mk(0,0,0,0,0,0,0,0,0), "R9 empty any", 0);
        // R10 second start while busy
        run_case(7'd40, '1, 7'd8, 2'd0, mk(1,0,0,0,0,0,0,1,0), "R10 busy start", 1);
        // R3 random mixes
        for (int n = 0; n < 60; n++) begin
            logic [63:0] pm;
            pm = {$urandom, $urandom};
            if (n % 3 == 0) pm = pm & {$urandom, $urandom};
            run_case(7'($urandom_range(0, 70)), pm, 7'($urandom), 2'($urandom),
                     vbr_mode_t'(9'($urandom)), "R3 random", 0);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule